// File: doc/BRIEF.md
# Per-Thread Instruction Line Prefetch Buffer Controller

This controller keeps the bookkeeping for one thread's instruction fetch buffer. The buffer is a ring of `DEPTH` slots, each one cache line of `LINE_BYTES` bytes. A slot is in one of three states: free, reserved (a fill is outstanding) or filled. The controller does not hold line data and does not extract instructions. Its job is to choose which line to fetch next and which slot receives it. It also returns slots to the free pool as the thread's program counter moves forward, and it discards all held lines when the thread is redirected.

When a fetch scheduler grants the thread through `fetch_go_i`, the controller issues the presented line address and slot index. It then records that line as reserved. A later fill notification that carries the same line address turns the slot into filled. While no slot is free, the controller compares the PC's line with the held lines to decide whether the oldest line can go back to the pool. A flush marks the next empty-buffer refill as a restart. On that refill the buffer read pointer starts at the PC's byte offset inside its line.

Top module: `fetch_line_buf_ctrl`

## Requirements
- R1: After reset all `DEPTH` slots are free, `has_space_o` and `req_valid_o` are 1, `req_slot_o` is 0 and `rd_ptr_o` is 0.
- R2: With no line held, `req_addr_o` equals `pc_i` with its low log2(`LINE_BYTES`) bits cleared. An issue from this empty state with no flush since reset leaves `rd_ptr_o` at 0.
- R3: With at least one line held, reserved or filled, `req_addr_o` equals the most recently issued line address plus `LINE_BYTES`.
- R4: A request issues in a cycle where `req_valid_o` and `fetch_go_i` are both 1. The issued slot is the head of a FIFO of free slot indices. After reset or flush the slots issue in order 0, 1, …, `DEPTH`-1. `has_space_o` goes to 0 once no slot is free.
- R5: A fill whose `fill_addr_i` matches a reserved line marks that line filled. A fill that matches no reserved line has no effect.
- R6: While no slot is free, if the oldest held line is filled and the PC's line is a different filled line, the oldest line's slot goes back to the tail of the free FIFO at the next edge. That slot then appears on `req_slot_o` with `has_space_o` = 1.
- R7: No line is released while the PC's line is only reserved, or while the PC lies in the oldest held line.
- R8: Release is considered only in cycles where no slot is free. At most one line is released per cycle.
- R9: `flush_i` forces `req_valid_o` to 0 in its cycle and discards any fill in that cycle. At the next edge it frees every slot in index order 0..`DEPTH`-1, clears `rd_ptr_o` to 0 and drops all held lines.
- R10: The first issue from an empty buffer after a flush sets `rd_ptr_o` to `pc_i` modulo `LINE_BYTES`. Later issues leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | ADDR_W | Current program counter of the thread |
| flush_i | input | 1 | Branch redirect: drop all held lines |
| fetch_go_i | input | 1 | Scheduler grant; issues the presented request |
| req_valid_o | output | 1 | A request can be issued this cycle |
| req_addr_o | output | ADDR_W | Line address of the request |
| req_slot_o | output | log2(DEPTH) | Slot that will receive the line |
| fill_valid_i | input | 1 | A line fill has completed |
| fill_addr_i | input | ADDR_W | Line address of the completed fill |
| has_space_o | output | 1 | At least one slot is free |
| rd_ptr_o | output | log2(LINE_BYTES*DEPTH) | Byte read pointer into the buffer |

## Verification
Several rules are checked on every cycle by assertions:
- the free and held counts always add up to the slot count;
- each issue advances the presented address by exactly one line;
- a release is followed by free space with the released slot at the free head;
- a flush leaves slot 0 presented and the read pointer at zero;
- no duplicate line is ever reserved.

Other behaviour can only be shown by the bench's scenarios:
- a release is held back while the PC's line is still reserved or is the oldest line;
- a release waits until the buffer is full;
- a stale fill after a flush is ignored;
- the read-pointer restart offset comes out right, swept over every byte offset of a line.

// File: rtl/fbm_pkg.sv
package fbm_pkg;
  typedef enum logic {
    LN_RSVD   = 1'b0,
    LN_FILLED = 1'b1
  } line_st_e;
endpackage

// File: rtl/fbm_free_fifo.sv
module fbm_free_fifo #(
  parameter int DEPTH = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic                         pop_i,
  input  logic                         push_i,
  input  logic [$clog2(DEPTH)-1:0]     push_slot_i,
  output logic [$clog2(DEPTH)-1:0]     head_o,
  output logic [$clog2(DEPTH+1)-1:0]   cnt_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [IDX_W-1:0] slot_q [DEPTH];
  logic [IDX_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= IDX_W'(i);
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= CNT_W'(DEPTH);
    end else if (flush_i) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= IDX_W'(i);
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= CNT_W'(DEPTH);
    end else begin
      if (pop_i) rd_q <= rd_q + 1'b1;
      if (push_i) begin
        slot_q[wr_q] <= push_slot_i;
        wr_q         <= wr_q + 1'b1;
      end
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  assign head_o = slot_q[rd_q];
  assign cnt_o  = cnt_q;

  // R4
  pop_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !flush_i) |-> (cnt_q != '0));
  // R8
  push_nonfull_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !flush_i) |-> (cnt_q != CNT_W'(DEPTH)));
endmodule

// File: rtl/fbm_line_tracker.sv
module fbm_line_tracker
  import fbm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       flush_i,
  input  logic                       push_i,
  input  logic [ADDR_W-1:0]          push_addr_i,
  input  logic [$clog2(DEPTH)-1:0]   push_slot_i,
  input  logic                       fill_i,
  input  logic [ADDR_W-1:0]          fill_addr_i,
  input  logic [ADDR_W-1:0]          pc_line_i,
  input  logic                       rel_en_i,
  output logic                       empty_o,
  output logic [ADDR_W-1:0]          newest_o,
  output logic                       rel_o,
  output logic [$clog2(DEPTH)-1:0]   rel_slot_o,
  output logic [$clog2(DEPTH+1)-1:0] cnt_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  // age-ordered ring: head_q oldest, tail_q-1 newest
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [IDX_W-1:0]  slot_q [DEPTH];
  line_st_e          st_q   [DEPTH];
  logic [IDX_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  cnt_q;

  logic [DEPTH-1:0] held, fill_hit, pc_hit, dup_hit, filled;

  for (genvar j = 0; j < DEPTH; j++) begin : g_ent
    logic [IDX_W-1:0] age;
    assign age         = IDX_W'(j) - head_q;
    assign held[j]     = {1'b0, age} < cnt_q;
    assign filled[j]   = held[j] && (st_q[j] == LN_FILLED);
    assign fill_hit[j] = fill_i && held[j] && (st_q[j] == LN_RSVD) && (addr_q[j] == fill_addr_i);
    assign pc_hit[j]   = held[j] && (addr_q[j] == pc_line_i);
    assign dup_hit[j]  = held[j] && (addr_q[j] == push_addr_i);
  end

  logic pc_filled, pc_is_head;
  assign pc_filled  = |(pc_hit & filled);
  assign pc_is_head = pc_hit[head_q];

  assign rel_o      = rel_en_i && !flush_i && (cnt_q != '0) && filled[head_q] &&
                      pc_filled && !pc_is_head;
  assign rel_slot_o = slot_q[head_q];
  assign empty_o    = (cnt_q == '0);
  assign newest_o   = addr_q[tail_q - 1'b1];
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        addr_q[i] <= '0;
        slot_q[i] <= '0;
        st_q[i]   <= LN_RSVD;
      end
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      for (int i = 0; i < DEPTH; i++) st_q[i] <= LN_RSVD;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (fill_hit[i]) st_q[i] <= LN_FILLED;
      if (push_i) begin
        addr_q[tail_q] <= push_addr_i;
        slot_q[tail_q] <= push_slot_i;
        st_q[tail_q]   <= LN_RSVD;
        tail_q         <= tail_q + 1'b1;
      end
      if (rel_o) head_q <= head_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(rel_o);
    end
  end

  // R4
  dup_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (dup_hit == '0));
  // R5
  one_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fill_hit));
  // R4
  ring_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (cnt_q != CNT_W'(DEPTH)));
endmodule

// File: rtl/fetch_line_buf_ctrl.sv
module fetch_line_buf_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int DEPTH      = 4
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic [ADDR_W-1:0]                      pc_i,
  input  logic                                   flush_i,
  input  logic                                   fetch_go_i,
  output logic                                   req_valid_o,
  output logic [ADDR_W-1:0]                      req_addr_o,
  output logic [$clog2(DEPTH)-1:0]               req_slot_o,
  input  logic                                   fill_valid_i,
  input  logic [ADDR_W-1:0]                      fill_addr_i,
  output logic                                   has_space_o,
  output logic [$clog2(LINE_BYTES*DEPTH)-1:0]    rd_ptr_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int BUF_W = $clog2(LINE_BYTES*DEPTH);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(LINE_BYTES - 1);

  initial line_pow2_chk: assert ((LINE_BYTES & (LINE_BYTES - 1)) == 0 && DEPTH >= 2);

  logic [ADDR_W-1:0] pc_line, trk_newest;
  logic [IDX_W-1:0]  free_head, rel_slot;
  logic [CNT_W-1:0]  free_cnt, held_cnt;
  logic              trk_empty, trk_rel, issue;
  logic [BUF_W-1:0]  rd_q;
  logic              restart_q;

  assign pc_line     = pc_i & ~OFF_MASK;
  assign has_space_o = (free_cnt != '0);
  assign req_valid_o = has_space_o && !flush_i;
  assign issue       = req_valid_o && fetch_go_i;
  assign req_addr_o  = trk_empty ? pc_line : trk_newest + ADDR_W'(LINE_BYTES);
  assign req_slot_o  = free_head;
  assign rd_ptr_o    = rd_q;

  fbm_free_fifo #(.DEPTH(DEPTH)) i_free (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .pop_i       (issue),
    .push_i      (trk_rel),
    .push_slot_i (rel_slot),
    .head_o      (free_head),
    .cnt_o       (free_cnt)
  );

  fbm_line_tracker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) i_trk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .push_i      (issue),
    .push_addr_i (req_addr_o),
    .push_slot_i (free_head),
    .fill_i      (fill_valid_i),
    .fill_addr_i (fill_addr_i),
    .pc_line_i   (pc_line),
    .rel_en_i    (!has_space_o),
    .empty_o     (trk_empty),
    .newest_o    (trk_newest),
    .rel_o       (trk_rel),
    .rel_slot_o  (rel_slot),
    .cnt_o       (held_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q      <= '0;
      restart_q <= 1'b0;
    end else if (flush_i) begin
      rd_q      <= '0;
      restart_q <= 1'b1;
    end else if (issue && trk_empty) begin
      rd_q      <= restart_q ? BUF_W'(pc_i & OFF_MASK) : '0;
      restart_q <= 1'b0;
    end
  end

  // R4
  slot_conserve_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(free_cnt) + 32'(held_cnt)) == DEPTH);
  // R3
  next_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue |=> (req_addr_o == $past(req_addr_o) + ADDR_W'(LINE_BYTES)));
  // R6
  release_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trk_rel && !flush_i) |=> (has_space_o && req_slot_o == $past(rel_slot)));
  // R9
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (has_space_o && req_slot_o == '0 && rd_ptr_o == '0));
  // R10
  restart_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && trk_empty && restart_q) |=> (rd_ptr_o == BUF_W'($past(pc_i) & OFF_MASK)));
endmodule

// File: tb/test_fetch_line_buf_ctrl.sv
module test_fetch_line_buf_ctrl;
  localparam int AW = 16;
  localparam int LB = 16;
  localparam int DP = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] pc = 16'h0105;
  logic          flush = 1'b0, go = 1'b0, fill_v = 1'b0;
  logic [AW-1:0] fill_a = '0;
  logic          req_v, space;
  logic [AW-1:0] req_a;
  logic [1:0]    req_s;
  logic [5:0]    rdp;

  int total = 0, bad = 0, cyc = 0;

  always #10 clk = ~clk;

  fetch_line_buf_ctrl #(.ADDR_W(AW), .LINE_BYTES(LB), .DEPTH(DP)) i_fetch_line_buf_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .pc_i(pc), .flush_i(flush), .fetch_go_i(go),
    .req_valid_o(req_v), .req_addr_o(req_a), .req_slot_o(req_s),
    .fill_valid_i(fill_v), .fill_addr_i(fill_a), .has_space_o(space), .rd_ptr_o(rdp)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #2;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #2;
    // R1 / R2 reset state
    chk(space == 1'b1, "R1 space", int'(space), 1);
    chk(req_v == 1'b1, "R1 valid", int'(req_v), 1);
    chk(req_s == 2'd0, "R1 slot", int'(req_s), 0);
    chk(rdp == 6'd0, "R1 rdptr", int'(rdp), 0);
    chk(req_a == 16'h0100, "R2 empty addr", int'(req_a), 'h100);

    // R3 / R4 sequential reserve
    go = 1'b1;
    for (int k = 0; k < DP; k++) begin
      chk(req_s == 2'(k), "R4 slot order", int'(req_s), k);
      chk(req_a == 16'h0100 + 16'(LB*k), "R3 next addr", int'(req_a), 'h100 + LB*k);
      step();
    end
    go = 1'b0;
    #1;
    chk(space == 1'b0, "R4 full", int'(space), 0);
    chk(req_v == 1'b0, "R4 valid low", int'(req_v), 0);
    chk(rdp == 6'd0, "R2 rdptr no flush", int'(rdp), 0);

    // R7 PC line only reserved
    pc = 16'h0115;
    step(); step();
    chk(space == 1'b0, "R7 reserved pc", int'(space), 0);

    // R5 fills, R7 pc in oldest line
    pc = 16'h0105;
    fill_v = 1'b1; fill_a = 16'h0100; step();
    fill_a = 16'h0110; step();
    fill_a = 16'h0200; step();
    fill_v = 1'b0; step();
    chk(space == 1'b0, "R7 pc in oldest", int'(space), 0);

    // R6 release oldest
    pc = 16'h0115;
    step();
    chk(space == 1'b1, "R6 space", int'(space), 1);
    chk(req_s == 2'd0, "R6 slot", int'(req_s), 0);
    chk(req_a == 16'h0140, "R3 addr after release", int'(req_a), 'h140);
    step();
    chk(req_s == 2'd0 && space, "R8 single release", int'(req_s), 0);

    pc = 16'h0125;
    go = 1'b1; step(); go = 1'b0; #1;
    chk(space == 1'b0, "R4 refull", int'(space), 0);
    step();
    chk(space == 1'b0, "R7 reserved pc 2", int'(space), 0);
    fill_v = 1'b1; fill_a = 16'h0120; step(); fill_v = 1'b0; #1;
    chk(space == 1'b0, "R6 not yet", int'(space), 0);
    step();
    chk(space == 1'b1 && req_s == 2'd1, "R6 slot1", int'(req_s), 1);
    chk(req_a == 16'h0150, "R3 addr 0x150", int'(req_a), 'h150);

    // R8 no release while a slot is free
    fill_v = 1'b1; fill_a = 16'h0130; step(); fill_v = 1'b0;
    pc = 16'h0135;
    step(); step();
    chk(req_s == 2'd1, "R8 head unchanged", int'(req_s), 1);
    go = 1'b1; step(); go = 1'b0; #1;
    chk(space == 1'b0, "R8 full after issue", int'(space), 0);
    step();
    chk(space == 1'b1 && req_s == 2'd2, "R6 slot2", int'(req_s), 2);
    chk(req_a == 16'h0160, "R3 addr 0x160", int'(req_a), 'h160);

    // R9 flush
    pc = 16'h02A7; flush = 1'b1; fill_v = 1'b1; fill_a = 16'h0140; #1;
    chk(req_v == 1'b0, "R9 valid in flush", int'(req_v), 0);
    step(); flush = 1'b0; fill_v = 1'b0; #1;
    chk(space == 1'b1 && req_s == 2'd0, "R9 slot0", int'(req_s), 0);
    chk(req_a == 16'h02A0, "R9 addr", int'(req_a), 'h2A0);
    chk(rdp == 6'd0, "R9 rdptr", int'(rdp), 0);
    go = 1'b1;
    for (int k = 0; k < DP; k++) begin
      chk(req_s == 2'(k), "R9 slot order", int'(req_s), k);
      step();
    end
    go = 1'b0; #1;
    chk(rdp == 6'd7, "R10 restart offset", int'(rdp), 7);

    // R5 stale fill ignored
    fill_v = 1'b1; fill_a = 16'h0140; step();
    pc = 16'h02B7; fill_a = 16'h02B0; step();
    fill_v = 1'b0; step();
    chk(space == 1'b0, "R5 stale ignored", int'(space), 0);
    fill_v = 1'b1; fill_a = 16'h02A0; step(); fill_v = 1'b0; #1;
    chk(space == 1'b0, "R6 one edge late", int'(space), 0);
    step();
    chk(space == 1'b1 && req_s == 2'd0, "R6 slot0 after fill", int'(req_s), 0);
    chk(req_a == 16'h02E0, "R3 addr 0x2E0", int'(req_a), 'h2E0);

    // R10 sweep of every offset
    for (int off = 0; off < LB; off++) begin
      logic [AW-1:0] p;
      p = 16'h0400 + 16'(off << 6) + 16'(off);
      pc = p; flush = 1'b1; step(); flush = 1'b0; #1;
      chk(rdp == 6'd0, "R9 rdptr sweep", int'(rdp), 0);
      chk(req_a == (p & 16'hFFF0), "R2 addr sweep", int'(req_a), int'(p & 16'hFFF0));
      go = 1'b1; step(); go = 1'b0; #1;
      chk(rdp == 6'(off), "R10 rdptr sweep", int'(rdp), off);
      chk(req_a == (p & 16'hFFF0) + 16'd16, "R3 addr sweep", int'(req_a), int'((p & 16'hFFF0) + 16'd16));
      go = 1'b1; step(); go = 1'b0; #1;
      chk(rdp == 6'(off), "R10 rdptr held", int'(rdp), off);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule